// File: doc/BRIEF.md
# UART Transmitter with Programmable Framing

This block turns bytes written by a host into asynchronous serial frames. Its timing comes from a single-cycle enable, `tickEn`, that pulses at sixteen times the bit rate. A frame is made of a start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and a stop phase of one, one and a half or two bit times. When the line has nothing to send, it rests high.

Host writes go into a holding stage. In register mode the stage holds one character. In FIFO mode it holds sixteen. The framer moves each character from the holding stage into its own shift register, so the host can write while a frame is still on the line. When a character is waiting as the last stop tick ends, the next frame starts on the very next tick, with no idle gap. A break input pulls the line low for as long as it is held and does not disturb the framer's timing. Two status outputs report whether the holding stage is empty and whether the whole transmitter is idle.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txOut` is 1, `holdEmpty` is 1 and `txEmpty` is 1.
- R2: A frame begins with a start bit that is 16 ticks of `txOut`=0. Each data bit is 16 ticks long, and the data goes out least significant bit first.
- R3: `dataLen` selects the character length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits above the selected length are not sent.
- R4: When `parityEn`=1, one 16-tick parity bit follows the last data bit. With `parityOdd`=0 the parity bit makes the count of ones in the data plus parity even. With `parityOdd`=1 it makes that count odd.
- R5: The stop phase is `txOut`=1 for 16 ticks when `stopLong`=0. When `stopLong`=1 it lasts 24 ticks if `dataLen`=0 and 32 ticks for any other length.
- R6: If the holding stage has a character when the final stop tick ends, that character's start bit begins on the very next tick.
- R7: The holding stage takes 1 character when `fifoMode`=0 and 16 characters when `fifoMode`=1. A write made while the stage is full is ignored, and the characters already stored go out unchanged.
- R8: `holdEmpty` is 1 exactly when the holding stage is empty. `txEmpty` is 1 only when the holding stage is empty and no frame is being sent.
- R9: While `breakCtl`=1, `txOut` is 0. Frame timing carries on underneath, so the frame resumes at its correct position when the break is released.
- R10: No framing state advances in cycles where `tickEn`=0. A character written while ticks are stopped stays in the holding stage, and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Enable pulse at 16x the bit rate |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 8 | Character to transmit |
| fifoMode | input | 1 | 1 selects the 16-deep holding FIFO, 0 selects the single holding register |
| dataLen | input | 2 | Character length code: 0 is 5 bits, 3 is 8 bits |
| parityEn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stopLong | input | 1 | 0 gives 1 stop bit; 1 gives 1.5 stop bits for 5-bit characters and 2 stop bits otherwise |
| breakCtl | input | 1 | Forces the line low |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding stage is empty |
| txEmpty | output | 1 | Holding stage and shift register are both idle |

## Verification
The bench samples the line once per tick and compares every tick of every frame against the expected frame. A design that got the stop-length rule wrong would show up in the 5-bit and 6-bit cases, because it would give both the same 24-tick or 32-tick stop. A design with an off-by-one gap between frames would be caught by the back-to-back runs: it would show a high tick, or a shortened start bit, where the next start bit should begin. The bench also writes one character past a full register and past a full 16-deep FIFO. A design that overwrote a stored character would send a wrong byte, and one that queued the extra character would send one frame too many. The break test checks that the frame picks up at the correct bit once the break is released, and not from its beginning.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   shift;
    phase_e phase;
  } ctrlStrobe_t;
endpackage

// File: rtl/txf_hold.sv
module txf_hold #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoMode,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] CAP_FIFO = AW'(DEPTH) == 0 ? (AW+1)'(DEPTH) : (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic [AW:0]      cap;
  logic             full, push;

  assign cap   = fifoMode ? CAP_FIFO : (AW+1)'(1);
  assign full  = count >= cap;
  assign empty = count == '0;
  assign push  = wrEn && !full;
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R7: a write into a full stage leaves the occupancy alone
  p_full_write_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !pop) |=> (count == $past(count)));

  // R8: the control only takes a character that is really there
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl
  import txf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        holdEmpty,
  input  logic [1:0]  dataLen,
  input  logic        parityEn,
  input  logic        stopLong,
  output ctrlStrobe_t strb
);
  localparam logic [4:0] BIT_LAST = 5'd15;

  phase_e     state;
  logic [4:0] cnt;
  logic [2:0] bitIdx;
  logic [2:0] lastIdx;
  logic [4:0] stopLast;
  logic       stopEnd;

  assign lastIdx  = {1'b0, dataLen} + 3'd4;
  assign stopLast = !stopLong ? 5'd15 : ((dataLen == 2'd0) ? 5'd23 : 5'd31);
  assign stopEnd  = (state == PH_STOP) && (cnt == stopLast);

  always_comb begin
    strb.phase = state;
    strb.load  = tickEn && !holdEmpty && ((state == PH_IDLE) || stopEnd);
    strb.shift = tickEn && (state == PH_DATA) && (cnt == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tickEn) begin
      case (state)
        PH_IDLE: begin
          if (strb.load) begin
            state <= PH_START;
            cnt   <= '0;
          end
        end
        PH_START: begin
          if (cnt == BIT_LAST) begin
            state  <= PH_DATA;
            cnt    <= '0;
            bitIdx <= '0;
          end else cnt <= cnt + 5'd1;
        end
        PH_DATA: begin
          if (cnt == BIT_LAST) begin
            cnt <= '0;
            if (bitIdx == lastIdx) state <= parityEn ? PH_PARITY : PH_STOP;
            else bitIdx <= bitIdx + 3'd1;
          end else cnt <= cnt + 5'd1;
        end
        PH_PARITY: begin
          if (cnt == BIT_LAST) begin
            state <= PH_STOP;
            cnt   <= '0;
          end else cnt <= cnt + 5'd1;
        end
        PH_STOP: begin
          if (stopEnd) begin
            state <= strb.load ? PH_START : PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 5'd1;
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // R10: nothing moves between ticks
  p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(state) && $stable(cnt) && $stable(bitIdx)));

  // R6: a load always opens a fresh start bit on the following cycle
  p_load_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (state == PH_START && cnt == 5'd0));
endmodule

// File: rtl/txf_shift.sv
module txf_shift
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              breakCtl,
  input  logic [DATA_W-1:0] loadData,
  input  logic [1:0]        dataLen,
  input  logic              parityOdd,
  output logic              txOut
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;
  logic              parBit;

  assign mask   = {DATA_W{1'b1}} >> (2'd3 - dataLen);
  assign masked = loadData & mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
    end else if (strb.load) begin
      shReg  <= masked;
      parBit <= (^masked) ^ parityOdd;
    end else if (strb.shift) begin
      shReg  <= shReg >> 1;
    end
  end

  always_comb begin
    if (breakCtl) txOut = 1'b0;
    else begin
      case (strb.phase)
        PH_START:  txOut = 1'b0;
        PH_DATA:   txOut = shReg[0];
        PH_PARITY: txOut = parBit;
        default:   txOut = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import txf_pkg::*;
#(
  parameter int HOLD_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       fifoMode,
  input  logic [1:0] dataLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       stopLong,
  input  logic       breakCtl,
  output logic       txOut,
  output logic       holdEmpty,
  output logic       txEmpty
);
  ctrlStrobe_t       strb;
  logic [DATA_W-1:0] holdData;

  txf_hold #(.WIDTH(DATA_W), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .wrEn(wrEn), .wrData(wrData),
    .pop(strb.load), .rdData(holdData), .empty(holdEmpty)
  );

  txf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdEmpty(holdEmpty),
    .dataLen(dataLen), .parityEn(parityEn), .stopLong(stopLong), .strb(strb)
  );

  txf_shift u_shift (
    .clk(clk), .rstN(rstN), .strb(strb), .breakCtl(breakCtl), .loadData(holdData),
    .dataLen(dataLen), .parityOdd(parityOdd), .txOut(txOut)
  );

  assign txEmpty = holdEmpty && (strb.phase == PH_IDLE);

  // R1: an idle transmitter holds the line high unless breaking
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakCtl) |-> txOut);
endmodule

// File: tb/uart_tx_framer_bench.sv
`timescale 1ns/1ps
module uart_tx_framer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0, fifoMode = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] dataLen = 2'd3;
  logic parityEn = 1'b0, parityOdd = 1'b0, stopLong = 1'b0, breakCtl = 1'b0;
  logic txOut, holdEmpty, txEmpty;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  uart_tx_framer u_uart_tx_framer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .fifoMode(fifoMode), .dataLen(dataLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .stopLong(stopLong), .breakCtl(breakCtl), .txOut(txOut), .holdEmpty(holdEmpty),
    .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lenBits();
    return 5 + int'(dataLen);
  endfunction

  function automatic int stopTicks();
    if (!stopLong) return 16;
    return (dataLen == 2'd0) ? 24 : 32;
  endfunction

  function automatic int frameTicks();
    return 16 * (1 + lenBits() + int'(parityEn)) + stopTicks();
  endfunction

  // segment 0 start, 1 data, 2 parity, 3 stop
  function automatic int segOf(input int s);
    int b = s / 16;
    if (b == 0) return 0;
    if (b <= lenBits()) return 1;
    if (parityEn && b == lenBits() + 1) return 2;
    return 3;
  endfunction

  function automatic logic expSample(input logic [7:0] c, input int s);
    int b = s / 16;
    int ones = 0;
    for (int i = 0; i < lenBits(); i++) ones += int'(c[i]);
    case (segOf(s))
      0: return 1'b0;
      1: return c[b-1];
      2: return logic'(ones % 2) ^ parityOdd;
      default: return 1'b1;
    endcase
  endfunction

  task automatic doTick();
    @(negedge clk) tickEn = 1'b1;
    @(negedge clk) tickEn = 1'b0;
  endtask

  task automatic writeChar(input logic [7:0] b);
    @(negedge clk) begin wrEn = 1'b1; wrData = b; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic runFrame(input logic [7:0] c, input bit last, input int brkLo, input int brkHi,
                          input int midAt, input logic [7:0] midChar);
    int mis[4];
    int fa[4];
    int fe[4];
    logic e;
    for (int k = 0; k < 4; k++) begin mis[k] = 0; fa[k] = 0; fe[k] = 0; end
    for (int s = 0; s < frameTicks(); s++) begin
      breakCtl = (s >= brkLo && s < brkHi);
      if (s == midAt) writeChar(midChar);
      doTick();
      e = breakCtl ? 1'b0 : expSample(c, s);
      if (txOut !== e) begin
        if (mis[segOf(s)] == 0) begin fa[segOf(s)] = int'(txOut); fe[segOf(s)] = int'(e); end
        mis[segOf(s)]++;
      end
      if (s == 0 && last) check(holdEmpty && !txEmpty, "R8 busy status", int'({holdEmpty, txEmpty}), 2);
    end
    breakCtl = 1'b0;
    check(mis[0] == 0, (brkHi > brkLo) ? "R9 start/break" : "R2 start bit", fa[0], fe[0]);
    check(mis[1] == 0, (brkHi > brkLo) ? "R9 data under break" : "R3 data bits", fa[1], fe[1]);
    if (parityEn) check(mis[2] == 0, "R4 parity bit", fa[2], fe[2]);
    check(mis[3] == 0, "R5 stop length", fa[3], fe[3]);
  endtask

  task automatic idleCheck(input string tag);
    doTick();
    check(txOut === 1'b1 && txEmpty === 1'b1, tag, int'({txOut, txEmpty}), 3);
  endtask

  task automatic setCfg(input logic [1:0] l, input logic pe, input logic po, input logic sl);
    dataLen = l; parityEn = pe; parityOdd = po; stopLong = sl;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] chars[16];
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut === 1'b1 && holdEmpty === 1'b1 && txEmpty === 1'b1, "R1 reset state",
          int'({txOut, holdEmpty, txEmpty}), 7);

    // R10: ticks stopped, character waits
    setCfg(2'd3, 1'b0, 1'b0, 1'b0);
    writeChar(8'hA5);
    repeat (20) @(negedge clk);
    check(txOut === 1'b1 && holdEmpty === 1'b0 && txEmpty === 1'b0, "R10 no tick no motion",
          int'({txOut, holdEmpty, txEmpty}), 4);
    runFrame(8'hA5, 1'b1, 0, 0, -1, 8'h00);
    idleCheck("R1 idle after frame");

    // R7 register mode: second write dropped
    writeChar(8'h3C);
    writeChar(8'hC3);
    runFrame(8'h3C, 1'b1, 0, 0, -1, 8'h00);
    idleCheck("R7 register overflow dropped");

    // R7 FIFO mode: 17 writes, 16 kept, back-to-back (R6)
    fifoMode = 1'b1;
    setCfg(2'd2, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 17; i++) writeChar(8'(i * 29 + 7));
    for (int i = 0; i < 16; i++) runFrame(8'(i * 29 + 7), i == 15, 0, 0, -1, 8'h00);
    idleCheck("R7 FIFO overflow dropped");

    // R5 corners: 1.5 stop with 5 bits, 2 stop with 6 bits; R6 chain
    setCfg(2'd0, 1'b1, 1'b0, 1'b1);
    writeChar(8'h15); writeChar(8'hEA);
    runFrame(8'h15, 1'b0, 0, 0, -1, 8'h00);
    runFrame(8'hEA, 1'b1, 0, 0, -1, 8'h00);
    idleCheck("R6 chain ends idle");
    setCfg(2'd1, 1'b0, 1'b0, 1'b1);
    writeChar(8'h2B);
    runFrame(8'h2B, 1'b1, 0, 0, -1, 8'h00);
    idleCheck("R5 two stop idle");

    // R9 break in the middle of a frame
    setCfg(2'd3, 1'b1, 1'b0, 1'b0);
    writeChar(8'hFF);
    runFrame(8'hFF, 1'b1, 20, 60, -1, 8'h00);
    idleCheck("R9 idle after break");

    // random configurations
    for (int it = 0; it < 18; it++) begin
      setCfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      fifoMode = 1'($urandom % 2);
      if (fifoMode) begin
        n = 1 + int'($urandom % 3);
        for (int i = 0; i < n; i++) begin chars[i] = 8'($urandom); writeChar(chars[i]); end
        for (int i = 0; i < n; i++) runFrame(chars[i], i == n - 1, 0, 0, -1, 8'h00);
      end else begin
        chars[0] = 8'($urandom); chars[1] = 8'($urandom);
        writeChar(chars[0]);
        runFrame(chars[0], 1'b0, 0, 0, 5, chars[1]);
        runFrame(chars[1], 1'b1, 0, 0, -1, 8'h00);
      end
      idleCheck("R8 idle status after run");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule